// File: doc/BRIEF.md
# Legacy Peripheral Configuration Port

This block is the configuration front end of a legacy multi-function peripheral controller. Software reaches it through a two-byte I/O window: an index port, where a byte names one of the internal configuration registers, and a data port, which then reads or writes that register. Three byte registers hold the set-up: a function-enable register, a function-address register and a power/test register. On reset they load from default tables indexed by a 5-bit strap input, so the board picks a start-up layout without any software.

Reading the index port right after reset returns a fixed identification byte once. After that, or after any index write, the index port reads back the selected index. The register contents are decoded continuously into enable flags, legacy I/O base addresses and interrupt numbers for a parallel port, two serial ports, a floppy controller and a disk controller. A one-cycle pulse marks every data write that actually changes a register, so the surrounding logic knows when to re-map its devices.

The bus side is a plain strobe interface and has no back-pressure. A read or write strobe is taken in the cycle it is high and is never stalled. Read data comes back one cycle later with a valid flag that is high for one cycle. The consumer must take it in that cycle, because the port has no ready input and nothing is held for a retry.

Top module: `sio_cfg_port`

## Requirements
- R1: While `rst` is high the selected index becomes 0, the identification step restarts, and the three registers load the defaults for `strap_cfg`. Strap 1 gives enable 0x4F, address 0x11, power 0x00. Strap 6 gives 0x4B, 0x00, 0x00. Strap 31 gives 0x00, 0x10, 0x02.
- R2: `io_port` = 0 addresses the index port and `io_port` = 1 the data port. An index write stores `io_wdata` as the selected index, and later index reads return it.
- R3: The first index read after reset returns 0x88. Every later index read returns the selected index. An index write before any index read also ends the identification step.
- R4: A data write changes a register only when the selected index is 0 (enable), 1 (address) or 2 (power). With any other index the write has no effect, and a data read returns 0x00.
- R5: A read strobe produces `io_rdata` with `io_rvalid` high for exactly one cycle in the following cycle. If `io_wr` and `io_rd` are both high in a cycle, only the write is performed and no read data is returned.
- R6: `cfg_changed` is high for one cycle, in the cycle after a data write that gives a register a new value. It stays low when the write leaves the register unchanged.
- R7: The parallel port is enabled by enable bit 0. Address bits [1:0] give base 0x378, 0x3BC, 0x278 or 0x000 for the values 0, 1, 2, 3. The IRQ is 7 if power bit 3 is set and 5 otherwise when the field is 0, and 7, 5, 0 for the field values 1, 2, 3.
- R8: Serial port n is enabled by enable bit n+1 and uses address field bits [2n+3:2n+2]. Field 0 gives base 0x3F8 and field 1 gives 0x2F8. Field 2 gives 0x3E8, 0x338, 0x2E8 or 0x220, and field 3 gives 0x2E8, 0x238, 0x2E0 or 0x228, chosen by address bits [7:6]. The IRQ is 3 for an odd field and 4 for an even one.
- R9: The floppy controller is enabled by bit 3 and has base 0x370 when bit 5 is set, else 0x3F0, with IRQ 6. The disk controller is enabled by bit 6 and has base 0x170 when bit 7 is set, else 0x1F0, with IRQ 14. Its alternate base is its base plus 0x206.
- R10: Every decoded output shows the new register value in the cycle after the data write that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_cfg | input | 5 | Strap selecting the reset defaults |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_port | input | 1 | Address bit 0: 0 index port, 1 data port |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte |
| io_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| cfg_changed | output | 1 | One-cycle pulse after a register content change |
| par_en | output | 1 | Parallel port enabled |
| par_base | output | 16 | Parallel port base |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | Serial port enables, bit n for port n |
| uart_base | output | 32 | Serial bases, port n at bits [16n+15:16n] |
| uart_irq | output | 8 | Serial IRQs, port n at bits [4n+3:4n] |
| fdc_en | output | 1 | Floppy controller enabled |
| fdc_base | output | 16 | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | Disk controller enabled |
| ide_base | output | 16 | Disk controller base |
| ide_alt_base | output | 16 | Disk controller alternate base |
| ide_irq | output | 4 | Disk controller IRQ |

## Verification
Each result has a fixed latency. Read data and its valid flag, the change pulse and every decoded output are due one cycle after the strobe that causes them, because each of them sits behind exactly one register. The bench drives a strobe on a falling edge, lets exactly one rising edge pass, and checks all these outputs at the next falling edge. At that edge the reference model has already applied the same access. The reset defaults are checked on the first falling edge after reset is released.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W   = 8;
  localparam int IO_W     = 16;
  localparam int IRQ_W    = 4;
  localparam int STRAP_W  = 5;
  localparam int NUM_UART = 2;
  localparam int NUM_REG  = 3;
  localparam int SEL_W    = $clog2(NUM_REG);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [IO_W-1:0]   io_t;
  typedef logic [IRQ_W-1:0]  irq_t;

  typedef struct packed {
    byte_t ena;
    byte_t map;
    byte_t pwr;
  } cfg_regs_t;

  localparam byte_t ID_CODE = 8'h88;

  function automatic byte_t dflt_ena(input logic [STRAP_W-1:0] s);
    byte_t v;
    if (s <= 5'd5)       v = 8'h4F;
    else if (s <= 5'd11) v = 8'h4B;
    else if (s <= 5'd15) v = 8'h0F;
    else if (s <= 5'd19) v = 8'h49;
    else if (s <= 5'd23) v = 8'h07;
    else if (s <= 5'd29) v = 8'h47;
    else if (s == 5'd30) v = 8'h08;
    else                 v = 8'h00;
    return v;
  endfunction

  function automatic byte_t dflt_map(input logic [STRAP_W-1:0] s);
    byte_t v;
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: v = 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  v = 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
      5'd5, 5'd29:                             v = 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                v = 8'h01;
      5'd9:                                    v = 8'h09;
      5'd10, 5'd11:                            v = 8'h08;
      default:                                 v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic cfg_regs_t strap_defaults(input logic [STRAP_W-1:0] s);
    cfg_regs_t r;
    r.ena = dflt_ena(s);
    r.map = dflt_map(s);
    r.pwr = (s == 5'd31) ? 8'h02 : 8'h00;
    return r;
  endfunction
endpackage

// File: rtl/sio_cfg_bus.sv
module sio_cfg_bus
  import sio_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             io_port,
  input  byte_t            io_wdata,
  input  byte_t            reg_rvalue,
  output logic [SEL_W-1:0] reg_sel,
  output logic             reg_wr_en,
  output byte_t            io_rdata,
  output logic             io_rvalid
);
  byte_t sel_idx;
  logic  id_done;
  logic  sel_ok;

  assign sel_ok    = (sel_idx < BYTE_W'(NUM_REG));
  assign reg_sel   = sel_idx[SEL_W-1:0];
  assign reg_wr_en = io_wr && io_port && sel_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx   <= '0;
      id_done   <= 1'b0;
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= 1'b0;
      if (io_wr) begin
        if (!io_port) begin
          sel_idx <= io_wdata;
          id_done <= 1'b1;
        end
      end else if (io_rd) begin
        io_rvalid <= 1'b1;
        if (!io_port) begin
          if (!id_done) begin
            io_rdata <= ID_CODE;
            id_done  <= 1'b1;
          end else begin
            io_rdata <= sel_idx;
          end
        end else begin
          io_rdata <= sel_ok ? reg_rvalue : '0;
        end
      end
    end
  end

  // R5
  rd_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr) |=> io_rvalid);
  // R5
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && !io_wr) |=> !io_rvalid);
  // R3
  id_ends_on_index_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_port) |=> id_done);
  // R2
  index_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_port) |=> (sel_idx == $past(io_wdata)));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  byte_t              wdata,
  output cfg_regs_t          regs,
  output byte_t              rvalue,
  output logic               changed
);
  always_comb begin
    case (wr_sel)
      2'd0:    rvalue = regs.ena;
      2'd1:    rvalue = regs.map;
      default: rvalue = regs.pwr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs    <= strap_defaults(strap);
      changed <= 1'b0;
    end else begin
      changed <= wr_en && (rvalue != wdata);
      if (wr_en) begin
        case (wr_sel)
          2'd0:    regs.ena <= wdata;
          2'd1:    regs.map <= wdata;
          default: regs.pwr <= wdata;
        endcase
      end
    end
  end

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));
  // R6
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    changed |-> $past(wr_en));
  // R6
  pulse_means_change_chk: assert property (@(posedge clk) disable iff (rst)
    changed |-> (regs != $past(regs)));
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  cfg_regs_t                  regs,
  output logic                       par_en,
  output io_t                        par_base,
  output irq_t                       par_irq,
  output logic [NUM_UART-1:0]        uart_en,
  output logic [NUM_UART*IO_W-1:0]   uart_base,
  output logic [NUM_UART*IRQ_W-1:0]  uart_irq,
  output logic                       fdc_en,
  output io_t                        fdc_base,
  output irq_t                       fdc_irq,
  output logic                       ide_en,
  output io_t                        ide_base,
  output io_t                        ide_alt_base,
  output irq_t                       ide_irq
);
  localparam io_t  IDE_ALT_OFS = 16'h0206;
  localparam irq_t FDC_IRQ_NUM = 4'd6;
  localparam irq_t IDE_IRQ_NUM = 4'd14;

  always_comb begin
    par_en = regs.ena[0];
    case (regs.map[1:0])
      2'd0: begin par_base = 16'h0378; par_irq = regs.pwr[3] ? 4'd7 : 4'd5; end
      2'd1: begin par_base = 16'h03BC; par_irq = 4'd7; end
      2'd2: begin par_base = 16'h0278; par_irq = 4'd5; end
      default: begin par_base = 16'h0000; par_irq = 4'd0; end
    endcase
  end

  for (genvar n = 0; n < NUM_UART; n++) begin : g_uart
    logic [1:0] fld;
    io_t        base;
    assign fld = regs.map[2*n+3 -: 2];
    always_comb begin
      case (fld)
        2'd0: base = 16'h03F8;
        2'd1: base = 16'h02F8;
        2'd2: begin
          case (regs.map[7:6])
            2'd0: base = 16'h03E8;
            2'd1: base = 16'h0338;
            2'd2: base = 16'h02E8;
            default: base = 16'h0220;
          endcase
        end
        default: begin
          case (regs.map[7:6])
            2'd0: base = 16'h02E8;
            2'd1: base = 16'h0238;
            2'd2: base = 16'h02E0;
            default: base = 16'h0228;
          endcase
        end
      endcase
    end
    assign uart_en[n]               = regs.ena[n+1];
    assign uart_base[n*IO_W +: IO_W] = base;
    assign uart_irq[n*IRQ_W +: IRQ_W] = fld[0] ? 4'd3 : 4'd4;
  end

  assign fdc_en       = regs.ena[3];
  assign fdc_base     = regs.ena[5] ? 16'h0370 : 16'h03F0;
  assign fdc_irq      = FDC_IRQ_NUM;
  assign ide_en       = regs.ena[6];
  assign ide_base     = regs.ena[7] ? 16'h0170 : 16'h01F0;
  assign ide_alt_base = ide_base + IDE_ALT_OFS;
  assign ide_irq      = IDE_IRQ_NUM;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  strap_cfg,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        io_port,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        io_rvalid,
  output logic        cfg_changed,
  output logic        par_en,
  output logic [15:0] par_base,
  output logic [3:0]  par_irq,
  output logic [1:0]  uart_en,
  output logic [31:0] uart_base,
  output logic [7:0]  uart_irq,
  output logic        fdc_en,
  output logic [15:0] fdc_base,
  output logic [3:0]  fdc_irq,
  output logic        ide_en,
  output logic [15:0] ide_base,
  output logic [15:0] ide_alt_base,
  output logic [3:0]  ide_irq
);
  cfg_regs_t        regs;
  byte_t            rvalue;
  logic [SEL_W-1:0] reg_sel;
  logic             reg_wr_en;

  sio_cfg_bus u_bus (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_port(io_port),
    .io_wdata(io_wdata), .reg_rvalue(rvalue), .reg_sel(reg_sel),
    .reg_wr_en(reg_wr_en), .io_rdata(io_rdata), .io_rvalid(io_rvalid)
  );

  sio_cfg_regfile u_regs (
    .clk(clk), .rst(rst), .strap(strap_cfg), .wr_en(reg_wr_en),
    .wr_sel(reg_sel), .wdata(io_wdata), .regs(regs), .rvalue(rvalue),
    .changed(cfg_changed)
  );

  sio_cfg_decode u_dec (
    .regs(regs), .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
    .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
    .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
    .ide_en(ide_en), .ide_base(ide_base), .ide_alt_base(ide_alt_base),
    .ide_irq(ide_irq)
  );

  // R10
  uart0_en_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uart_en[0]) |-> $past(io_wr && io_port));
  // R10
  decode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(io_wr) |-> ($stable(par_base) && $stable(uart_base) && $stable(ide_base)));
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  logic clk = 0, rst = 1;
  logic [4:0] strap_cfg = 5'd1;
  logic io_wr = 0, io_rd = 0, io_port = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic io_rvalid, cfg_changed, par_en, fdc_en, ide_en;
  logic [15:0] par_base, fdc_base, ide_base, ide_alt_base;
  logic [3:0] par_irq, fdc_irq, ide_irq;
  logic [1:0] uart_en;
  logic [31:0] uart_base;
  logic [7:0] uart_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_ena, m_map, m_pwr, m_idx;
  bit m_id_done;

  always #5 clk = ~clk;

  sio_cfg_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_uart_base(input logic [1:0] f, input logic [1:0] t);
    logic [15:0] a [4] = '{16'h03E8, 16'h0338, 16'h02E8, 16'h0220};
    logic [15:0] b [4] = '{16'h02E8, 16'h0238, 16'h02E0, 16'h0228};
    if (f == 0) return 16'h03F8;
    if (f == 1) return 16'h02F8;
    return (f == 2) ? a[t] : b[t];
  endfunction

  task automatic check_decode(input string tag);
    logic [15:0] pb [4] = '{16'h0378, 16'h03BC, 16'h0278, 16'h0000};
    logic [3:0]  pi [4] = '{4'd5, 4'd7, 4'd5, 4'd0};
    logic [3:0] exp_pirq;
    exp_pirq = (m_map[1:0] == 0) ? (m_pwr[3] ? 4'd7 : 4'd5) : pi[m_map[1:0]];
    chk({"R7 par_en ", tag}, par_en, m_ena[0]);
    chk({"R7 par_base ", tag}, par_base, pb[m_map[1:0]]);
    chk({"R7 par_irq ", tag}, par_irq, exp_pirq);
    for (int n = 0; n < 2; n++) begin
      logic [1:0] f;
      f = m_map[2*n+2 +: 2];
      chk({"R8 uart_en ", tag}, uart_en[n], m_ena[n+1]);
      chk({"R8 uart_base ", tag}, uart_base[16*n +: 16], e_uart_base(f, m_map[7:6]));
      chk({"R8 uart_irq ", tag}, uart_irq[4*n +: 4], (f == 1 || f == 3) ? 4'd3 : 4'd4);
    end
    chk({"R9 fdc_en ", tag}, fdc_en, m_ena[3]);
    chk({"R9 fdc_base ", tag}, fdc_base, m_ena[5] ? 16'h0370 : 16'h03F0);
    chk({"R9 fdc_irq ", tag}, fdc_irq, 4'd6);
    chk({"R9 ide_en ", tag}, ide_en, m_ena[6]);
    chk({"R9 ide_base ", tag}, ide_base, m_ena[7] ? 16'h0170 : 16'h01F0);
    chk({"R9 ide_alt_base ", tag}, ide_alt_base, (m_ena[7] ? 16'h0170 : 16'h01F0) + 16'h0206);
    chk({"R9 ide_irq ", tag}, ide_irq, 4'd14);
  endtask

  task automatic do_reset(input logic [4:0] s, input logic [7:0] e, input logic [7:0] m,
                          input logic [7:0] p);
    @(negedge clk);
    strap_cfg = s; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    m_ena = e; m_map = m; m_pwr = p; m_idx = 0; m_id_done = 0;
    chk("R1 rvalid after reset", io_rvalid, 0);
    chk("R1 no pulse after reset", cfg_changed, 0);
    check_decode("R1 reset defaults");
  endtask

  task automatic do_write(input bit port, input logic [7:0] d);
    bit exp_pulse;
    exp_pulse = 0;
    @(negedge clk);
    io_wr = 1; io_port = port; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
    if (!port) begin m_idx = d; m_id_done = 1; end
    else if (m_idx == 0) begin exp_pulse = (m_ena != d); m_ena = d; end
    else if (m_idx == 1) begin exp_pulse = (m_map != d); m_map = d; end
    else if (m_idx == 2) begin exp_pulse = (m_pwr != d); m_pwr = d; end
    chk("R6 cfg_changed", cfg_changed, exp_pulse);
    chk("R5 no rvalid on write", io_rvalid, 0);
    check_decode("R10 after write");
  endtask

  task automatic do_read(input bit port, input string req);
    logic [7:0] e;
    if (!port) begin
      e = m_id_done ? m_idx : 8'h88;
      m_id_done = 1;
    end else begin
      e = (m_idx == 0) ? m_ena : (m_idx == 1) ? m_map : (m_idx == 2) ? m_pwr : 8'h00;
    end
    @(negedge clk);
    io_rd = 1; io_port = port;
    @(negedge clk);
    io_rd = 0;
    chk({"R5 rvalid ", req}, io_rvalid, 1);
    chk({req, " rdata"}, io_rdata, e);
    @(negedge clk);
    chk("R5 rvalid one cycle", io_rvalid, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(5'd1, 8'h4F, 8'h11, 8'h00);
    do_read(0, "R3 id byte");
    do_read(0, "R3 index after id");
    do_read(1, "R1 enable default");
    do_write(0, 8'd1); do_read(1, "R1 address default");
    do_write(0, 8'd2); do_read(1, "R1 power default");
    do_read(0, "R2 index readback");

    do_write(0, 8'd5);
    do_write(1, 8'hAA);
    do_read(1, "R4 invalid index read");
    do_write(0, 8'd0); do_read(1, "R4 enable untouched");

    do_write(1, m_ena);
    do_write(1, 8'hFF);

    for (int f = 0; f < 4; f++)
      for (int b = 0; b < 2; b++) begin
        do_write(0, 8'd2); do_write(1, b ? 8'h08 : 8'h00);
        do_write(0, 8'd1); do_write(1, 8'(f));
      end
    do_write(0, 8'd1);
    for (int t = 0; t < 4; t++)
      for (int f = 0; f < 4; f++) do_write(1, 8'((t << 6) | (f << 2) | (f << 4)));

    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) begin
        do_write(0, 8'(k)); do_write(1, 8'($urandom));
      end else if (k < 5) begin
        do_write(1, 8'($urandom));
      end else if (k == 5) begin
        do_write(0, 8'($urandom_range(3, 255)));
      end else if (k < 8) do_read(1, "R4 random data read");
      else do_read(0, "R2 random index read");
    end

    do_write(0, 8'd0);
    @(negedge clk);
    io_wr = 1; io_rd = 1; io_port = 1; io_wdata = 8'h3C;
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    chk("R5 write wins over read", io_rvalid, 0);
    m_ena = 8'h3C;
    check_decode("R5 simultaneous");

    do_reset(5'd31, 8'h00, 8'h10, 8'h02);
    do_write(0, 8'd3);
    do_read(0, "R3 index write ends id");
    do_reset(5'd6, 8'h4B, 8'h00, 8'h00);
    do_read(0, "R3 id after reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule